// File: doc/BRIEF.md
# Majority Integration Detector for Per-Frame Control Flags

A 16-bit control word and four per-channel flag bits (one per audio channel, marking chargeable content) arrive once per frame. The block filters every one of these 20 bits through a vote taken over a window of frames. A single corrupted frame, or a few of them, therefore cannot change what the block reports. A reported bit changes only when a clear majority of recent frames agrees on a new value. When the frames disagree, the last reported value stays in place.

Frames are marked by a one-cycle strobe. A frame-valid input qualifies each strobe. A frame taken while the receiver is out of sync is skipped and casts no vote. The block repeats a fixed cycle of 18 frame slots. The first 15 slots form the voting window. The last three slots do not vote. On the 18th strobe the block publishes a verdict for each bit and clears the tallies, so the next window starts empty. An update pulse marks each publication. The pulse is the point at which a downstream consumer should sample the outputs.

Top module: `maj_integrator`

## Requirements
- R1: While reset is asserted, and immediately after it is released, `ctl_word_o`, `chg_flag_o` and `upd_o` are all zero. Reset also restarts the 18-slot cycle, so that the next strobe is slot 1.
- R2: `upd_o` is high for exactly one cycle. It is high in the clock cycle after the rising edge that samples the 18th, 36th, 54th and later strobes since reset. Invalid strobes count toward this cadence.
- R3: At an update, an output bit becomes 1 if the bit was 1 in at least 12 of the valid frames in the window.
- R4: At an update, an output bit becomes 0 if the bit was 0 in at least 12 of the valid frames in the window.
- R5: At an update, a bit that reaches neither 12 ones nor 12 zeros keeps its previous value.
- R6: Only strobes in slots 1 to 15 of each cycle vote. The raw values presented at slots 16, 17 and 18 have no effect on any verdict.
- R7: A strobe with `frm_ok_i` low casts no vote, for either value. It still occupies its slot.
- R8: The outputs change only in the cycle in which `upd_o` is high.
- R9: Every update empties the tallies. Votes never carry from one window into the next.
- R10: Each of the 20 bits is judged on its own. The bits are ordered with control bits 15 to 0 and then flags 3 to 0, and a mixed pattern yields the per-bit verdict.
- R11: Without a strobe, nothing advances. Cycles with `frm_stb_i` low change neither the outputs nor the slot position, and they never raise `upd_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frm_stb_i | input | 1 | One-cycle frame strobe |
| frm_ok_i | input | 1 | Frame valid (receiver in sync); qualifies the strobe |
| ctl_raw_i | input | 16 | Raw control word of the current frame |
| chg_raw_i | input | 4 | Raw per-channel flag bits of the current frame |
| ctl_word_o | output | 16 | Integrated control word |
| chg_flag_o | output | 4 | Integrated per-channel flags |
| upd_o | output | 1 | One-cycle pulse after each publication |

## Verification
Two actions fall on the same clock edge at the 18th strobe. The verdict of the closing window is published, and the tallies are cleared for the next window. A fault in either action is hidden unless both are probed together. The bench follows a hold-producing window with a second weak window whose votes would cross the threshold if any count survived the clear. It then checks that the published value stays put and that the pulse lands on exactly that strobe. Invalid strobes and tail-slot data that would tip a verdict if they were counted are placed next to the threshold. This judges whether the skip logic and the slot gating act in the same cycle as a vote.

// File: rtl/maj_integrator_pkg.sv
package maj_integrator_pkg;

   typedef enum logic [1:0] {
      VERDICT_HOLD = 2'b00,
      VERDICT_ONE  = 2'b01,
      VERDICT_ZERO = 2'b10
   } verdict_e;

   // Verdict from the tally of ones and the count of valid votes.
   function automatic verdict_e judge(input int unsigned ones,
                                      input int unsigned votes,
                                      input int unsigned thr);
      if (ones >= thr)
         return VERDICT_ONE;
      else if ((votes - ones) >= thr)
         return VERDICT_ZERO;
      return VERDICT_HOLD;
   endfunction

endpackage

// File: rtl/maj_frame_seq.sv
module maj_frame_seq #(
   parameter int unsigned WIN    = 15,
   parameter int unsigned PERIOD = 18,
   localparam int unsigned PH_W  = $clog2(PERIOD),
   localparam int unsigned CNT_W = $clog2(WIN + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             stb_i,
   input  logic             ok_i,
   output logic             vote_o,
   output logic             decide_o,
   output logic [CNT_W-1:0] votes_o
);

   logic [PH_W-1:0]  slot_q;
   logic [CNT_W-1:0] votes_q;
   logic             in_win;
   logic             last_slot;

   assign in_win    = (slot_q < PH_W'(WIN));
   assign last_slot = (slot_q == PH_W'(PERIOD - 1));
   assign vote_o    = stb_i & ok_i & in_win;
   assign decide_o  = stb_i & last_slot;
   assign votes_o   = votes_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         slot_q <= '0;
      end else if (stb_i) begin
         slot_q <= last_slot ? '0 : slot_q + PH_W'(1);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         votes_q <= '0;
      end else if (decide_o) begin
         votes_q <= '0;
      end else if (vote_o) begin
         votes_q <= votes_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/maj_bit_vote.sv
module maj_bit_vote
   import maj_integrator_pkg::*;
#(
   parameter int unsigned WIN   = 15,
   parameter int unsigned THR   = 12,
   localparam int unsigned CNT_W = $clog2(WIN + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             vote_i,
   input  logic             decide_i,
   input  logic [CNT_W-1:0] votes_i,
   input  logic             raw_i,
   output logic             q_o
);

   logic [CNT_W-1:0] ones_q;
   logic             q_q;
   verdict_e         verdict;

   assign verdict = judge(int'(ones_q), int'(votes_i), THR);
   assign q_o     = q_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ones_q <= '0;
      end else if (decide_i) begin
         ones_q <= '0;
      end else if (vote_i && raw_i) begin
         ones_q <= ones_q + CNT_W'(1);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         q_q <= 1'b0;
      end else if (decide_i) begin
         unique case (verdict)
            VERDICT_ONE:  q_q <= 1'b1;
            VERDICT_ZERO: q_q <= 1'b0;
            default:      q_q <= q_q;
         endcase
      end
   end

endmodule

// File: rtl/maj_integrator.sv
module maj_integrator #(
   parameter int unsigned CW_W   = 16,
   parameter int unsigned NCH    = 4,
   parameter int unsigned WIN    = 15,
   parameter int unsigned THR    = 12,
   parameter int unsigned PERIOD = 18
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            frm_stb_i,
   input  logic            frm_ok_i,
   input  logic [CW_W-1:0] ctl_raw_i,
   input  logic [NCH-1:0]  chg_raw_i,
   output logic [CW_W-1:0] ctl_word_o,
   output logic [NCH-1:0]  chg_flag_o,
   output logic            upd_o
);

   localparam int unsigned NBITS = CW_W + NCH;
   localparam int unsigned CNT_W = $clog2(WIN + 1);

   // Elaboration-time parameter checks
   if (THR * 2 <= WIN) begin : g_bad_thr
      $error("THR must be a strict majority of WIN");
   end
   if (THR > WIN) begin : g_bad_thr_hi
      $error("THR cannot exceed WIN");
   end
   if (WIN >= PERIOD) begin : g_bad_period
      $error("the window must end before the publication slot");
   end
   if (CW_W == 0 || NCH == 0) begin : g_bad_width
      $error("widths must be non-zero");
   end

   logic             vote;
   logic             decide;
   logic [CNT_W-1:0] votes;
   logic [NBITS-1:0] raw_all;
   logic [NBITS-1:0] q_all;
   logic             upd_q;

   assign raw_all = {ctl_raw_i, chg_raw_i};

   maj_frame_seq #(
      .WIN    (WIN),
      .PERIOD (PERIOD)
   ) seq_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .stb_i    (frm_stb_i),
      .ok_i     (frm_ok_i),
      .vote_o   (vote),
      .decide_o (decide),
      .votes_o  (votes)
   );

   for (genvar g = 0; g < NBITS; g++) begin : g_bit
      maj_bit_vote #(
         .WIN (WIN),
         .THR (THR)
      ) vote_i (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .vote_i   (vote),
         .decide_i (decide),
         .votes_i  (votes),
         .raw_i    (raw_all[g]),
         .q_o      (q_all[g])
      );
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) upd_q <= 1'b0;
      else         upd_q <= decide;
   end

   assign ctl_word_o = q_all[NBITS-1:NCH];
   assign chg_flag_o = q_all[NCH-1:0];
   assign upd_o      = upd_q;

endmodule

// File: rtl/maj_integrator_chk.sv
module maj_integrator_chk #(
   parameter int unsigned CW_W   = 16,
   parameter int unsigned NCH    = 4,
   parameter int unsigned PERIOD = 18
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic            frm_stb_i,
   input logic [CW_W-1:0] ctl_word_o,
   input logic [NCH-1:0]  chg_flag_o,
   input logic            upd_o
);

   localparam int unsigned SC_W = $clog2(PERIOD);

   logic [SC_W-1:0] stb_cnt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         stb_cnt <= '0;
      else if (frm_stb_i)
         stb_cnt <= (stb_cnt == SC_W'(PERIOD - 1)) ? '0 : stb_cnt + SC_W'(1);
   end

   AST_UPD_ON_LAST_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frm_stb_i && stb_cnt == SC_W'(PERIOD - 1)) |=> upd_o);  // R2
   AST_NO_UPD_ELSEWHERE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(frm_stb_i && stb_cnt == SC_W'(PERIOD - 1)) |=> !upd_o); // R2
   AST_UPD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_o |=> !upd_o);  // R2
   AST_UPD_NEEDS_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_o |-> $past(frm_stb_i));  // R11
   AST_CTL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !upd_o |-> $stable(ctl_word_o));  // R8
   AST_FLAG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !upd_o |-> $stable(chg_flag_o));  // R8

endmodule

bind maj_integrator maj_integrator_chk #(
   .CW_W   (CW_W),
   .NCH    (NCH),
   .PERIOD (PERIOD)
) chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .frm_stb_i  (frm_stb_i),
   .ctl_word_o (ctl_word_o),
   .chg_flag_o (chg_flag_o),
   .upd_o      (upd_o)
);

// File: tb/maj_integrator_tb_top.sv
`timescale 1ns/1ps
module maj_integrator_tb_top;

   typedef struct packed {
      logic [19:0] a;
      logic [19:0] b;
      logic [19:0] tail;
      logic [19:0] expv;
      logic [4:0]  n_a;
      logic [4:0]  n_bad;
   } vec_t;

   // n_a valid slots of a, then n_bad invalid slots of a, then valid b up to
   // slot 15, then tail on slots 16..18.
   localparam int NV = 10;
   localparam vec_t TBL [NV] = '{
      '{20'hFFFFF, 20'h00000, 20'h00000, 20'hFFFFF, 5'd12, 5'd0},  // R3
      '{20'h00000, 20'hFFFFF, 20'hFFFFF, 20'h00000, 5'd12, 5'd0},  // R4
      '{20'hFFFFF, 20'h00000, 20'h00000, 20'hFFFFF, 5'd15, 5'd0},  // R3
      '{20'h00000, 20'hFFFFF, 20'h00000, 20'hFFFFF, 5'd11, 5'd0},  // R5
      '{20'hA5A53, 20'h5A5AC, 20'h5A5AC, 20'hA5A53, 5'd13, 5'd0},  // R10
      '{20'hFFFFF, 20'h00000, 20'hFFFFF, 20'hA5A53, 5'd9,  5'd0},  // R6
      '{20'h00000, 20'hFFFFF, 20'h00000, 20'hA5A53, 5'd10, 5'd3},  // R7
      '{20'h00000, 20'h00000, 20'hFFFFF, 20'h00000, 5'd12, 5'd3},  // R7
      '{20'hFFFFF, 20'h00000, 20'h00000, 20'h00000, 5'd8,  5'd0},  // R5
      '{20'hFFFFF, 20'h00000, 20'h00000, 20'h00000, 5'd5,  5'd0}   // R9
   };

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        frm_stb_i = 1'b0;
   logic        frm_ok_i = 1'b0;
   logic [15:0] ctl_raw_i = '0;
   logic [3:0]  chg_raw_i = '0;
   logic [15:0] ctl_word_o;
   logic [3:0]  chg_flag_o;
   logic        upd_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   string tags [NV];

   always #10 clk_i = ~clk_i;

   maj_integrator dut_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .frm_stb_i  (frm_stb_i),
      .frm_ok_i   (frm_ok_i),
      .ctl_raw_i  (ctl_raw_i),
      .chg_raw_i  (chg_raw_i),
      .ctl_word_o (ctl_word_o),
      .chg_flag_o (chg_flag_o),
      .upd_o      (upd_o)
   );

   task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%05h expected=%05h", req, act, exp);
      end
   endtask

   // One frame: strobe for one cycle; returns upd_o as seen after that edge.
   task automatic frame(input logic [19:0] v, input logic ok, output logic saw);
      @(negedge clk_i);
      frm_stb_i = 1'b1;
      frm_ok_i  = ok;
      {ctl_raw_i, chg_raw_i} = v;
      @(negedge clk_i);
      frm_stb_i = 1'b0;
      saw = upd_o;
      @(negedge clk_i);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic saw;
      logic [19:0] prev;
      tags = '{"R3", "R4", "R3", "R5", "R10", "R6", "R7", "R7", "R5", "R9"};

      // R1: reset state
      repeat (3) @(negedge clk_i);
      check("R1", {ctl_word_o, chg_flag_o}, 20'h0);
      check("R1", {19'h0, upd_o}, 20'h0);
      rst_ni = 1'b1;
      @(negedge clk_i);
      check("R1", {ctl_word_o, chg_flag_o}, 20'h0);

      // Table walk
      prev = 20'h0;
      for (int e = 0; e < NV; e++) begin
         for (int s = 0; s < 18; s++) begin
            if (s < int'(TBL[e].n_a))
               frame(TBL[e].a, 1'b1, saw);
            else if (s < int'(TBL[e].n_a) + int'(TBL[e].n_bad))
               frame(TBL[e].a, 1'b0, saw);
            else if (s < 15)
               frame(TBL[e].b, 1'b1, saw);
            else
               frame(TBL[e].tail, 1'b1, saw);
            if (s < 17) begin
               check("R2", {19'h0, saw}, 20'h0);
               check("R8", {ctl_word_o, chg_flag_o}, prev);
            end else begin
               check("R2", {19'h0, saw}, 20'h1);
               check(tags[e], {ctl_word_o, chg_flag_o}, TBL[e].expv);
            end
         end
         prev = TBL[e].expv;
      end

      // R7 and R2: a cycle of invalid strobes still publishes and holds
      for (int s = 0; s < 18; s++) begin
         frame(20'hFFFFF, 1'b0, saw);
         if (s == 17) check("R2", {19'h0, saw}, 20'h1);
      end
      check("R7", {ctl_word_o, chg_flag_o}, 20'h0);

      // R11: no strobes, toggling data, nothing moves
      for (int c = 0; c < 200; c++) begin
         @(negedge clk_i);
         {ctl_raw_i, chg_raw_i} = 20'(c * 7919);
         frm_ok_i = c[0];
         if (upd_o !== 1'b0 || {ctl_word_o, chg_flag_o} !== 20'h0)
            check("R11", {ctl_word_o, chg_flag_o} | {19'h0, upd_o}, 20'h0);
      end
      checks++;
      // R11: slot position unchanged, so the next 18 strobes publish on the 18th
      for (int s = 0; s < 18; s++) begin
         frame(20'hFFFFF, 1'b1, saw);
         if (s == 16) check("R11", {19'h0, saw}, 20'h0);
         if (s == 17) check("R11", {19'h0, saw}, 20'h1);
      end
      check("R3", {ctl_word_o, chg_flag_o}, 20'hFFFFF);

      // R1: reset in mid-cycle clears outputs and restarts the slot count
      for (int s = 0; s < 5; s++) frame(20'h00000, 1'b1, saw);
      @(negedge clk_i);
      rst_ni = 1'b0;
      @(negedge clk_i);
      check("R1", {ctl_word_o, chg_flag_o}, 20'h0);
      rst_ni = 1'b1;
      for (int s = 0; s < 18; s++) begin
         frame(20'h12345, 1'b1, saw);
         if (s == 16) check("R1", {19'h0, saw}, 20'h0);
         if (s == 17) check("R2", {19'h0, saw}, 20'h1);
      end
      check("R10", {ctl_word_o, chg_flag_o}, 20'h12345);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule